// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small, fully associative cache of page translations that sits beside a processor pipeline. A lookup gives a virtual address, the current process number, the access kind (load or store) and the privilege level. In the same cycle the block returns the physical address, or it raises one of two exception flags. One flag means no entry matched. The other means a user-mode store targeted a page without write permission. Each entry is keyed by the virtual page number together with a process number. Translations belonging to several processes can therefore stay resident across a context switch.

Software handles every miss. It writes the missing translation through a refill port. It clears stale state either with a global flush or with a flush limited to one process. The block keeps a per-entry usage bit and a per-entry modified bit up to date by itself. Software can read all usage bits as a vector and clear them together, which gives it a coarse approximation of recency. A refill goes to the first free slot it finds. When every slot is occupied, a free-running pseudo-random generator picks the slot to overwrite.

Top module: `xlat_cache`

## Requirements
- R1: An entry matches a lookup only when both its stored virtual page number (address bits 31:12) and its stored process number equal those of the lookup. Entries that share a page number but have different process numbers coexist and translate independently.
- R2: Only entries marked valid can match. After reset no entry is valid, `ref_bits` and `dirty_bits` read zero, and every lookup misses.
- R3: Every lookup that hits sets the usage bit of the matching slot; this bit is visible as bit i of `ref_bits` for slot i from the next cycle. Asserting `ref_clr` clears all usage bits.
- R4: A store that hits without a fault sets the modified bit of the matching slot, visible as bit i of `dirty_bits` from the next cycle.
- R5: A lookup that matches no entry raises `exc_miss`, holds `lk_hit` low, drives `lk_paddr` to zero and changes no stored state.
- R6: A user-mode store (`lk_user`=1) that hits an entry refilled with `fill_wr`=0 raises `exc_prot` and leaves that slot's modified bit clear. A user-mode load of the same entry raises no exception.
- R7: A supervisor store (`lk_user`=0) that hits a read-only entry raises no exception and sets the modified bit.
- R8: A refill first overwrites a valid entry that has the same page number and process number. Otherwise it uses the lowest-numbered invalid slot. Only when all slots are valid does it overwrite a slot picked by an 8-bit LFSR that advances every cycle.
- R9: On a hit, `lk_paddr` equals the stored 18-bit physical page number placed above the 12 untranslated offset bits of the virtual address.
- R10: `flush_all` clears every valid bit in one cycle, and a refill requested in the same cycle is dropped.
- R11: `flush_pid_en` clears the valid bit only of entries whose process number equals `flush_pid`. All other entries remain usable.
- R12: A refill stores the write permission given with it and clears the usage bit and the modified bit of the slot it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_pid | input | 8 | Current process number |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_paddr | output | 30 | Translated physical address |
| exc_miss | output | 1 | Miss exception |
| exc_prot | output | 1 | Write-protection exception |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pid | input | 8 | Process number to install |
| fill_ppn | input | 18 | Physical page number to install |
| fill_wr | input | 1 | User writes allowed for this page |
| flush_all | input | 1 | Invalidate all entries |
| flush_pid_en | input | 1 | Invalidate entries of one process |
| flush_pid | input | 8 | Process number for the selective flush |
| ref_clr | input | 1 | Clear all usage bits |
| ref_bits | output | 16 | Usage bit of each slot |
| dirty_bits | output | 16 | Modified bit of each slot |

## Verification
The hardest case to reach from the ports is replacement in a full buffer. The victim slot comes from a generator that runs every cycle, so its choice cannot be predicted. The bench therefore fills all sixteen slots with distinct pages and then installs one more page. It does not look for a particular slot. It probes every older page and requires that exactly one of them now misses while the new page hits. The lowest-free-slot rule is different: it is deterministic, and the bench reaches it by flushing one process to leave holes in a known pattern. It then refills once, clears the usage bits, hits the new entry and reads back which usage bit became set.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int NUM_ENT = 16;
  localparam int VPN_W   = 20;
  localparam int PID_W   = 8;
  localparam int PPN_W   = 18;
  localparam int OFS_W   = 12;
  localparam int LFSR_W  = 8;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int VA_W    = VPN_W + OFS_W;
  localparam int PA_W    = PPN_W + OFS_W;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PPN_W-1:0] ppn;
    logic             wr;
  } xlat_ent_t;

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [OFS_W-1:0] ofs);
    return {ppn, ofs};
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int N  = NUM_ENT,
  parameter int IW = IDX_W
) (
  input  xlat_ent_t         ent_i   [N],
  input  logic [N-1:0]      valid_i,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [PID_W-1:0]  key_pid,
  output logic [N-1:0]      hit_vec,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (ent_i[g].vpn == key_vpn) && (ent_i[g].pid == key_pid);
  end

  assign hit = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int N  = NUM_ENT,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_i,
  input  logic          same_hit,
  input  logic [IW-1:0] same_idx,
  output logic [IW-1:0] slot_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              any_free;
  logic [IW-1:0]     free_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= LFSR_W'(1);
    else        lfsr_q <= lfsr_step(lfsr_q);
  end

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IW'(i);
    end
  end

  assign any_free = ~&valid_i;

  always_comb begin
    if (same_hit)      slot_o = same_idx;
    else if (any_free) slot_o = free_idx;
    else               slot_o = lfsr_q[IW-1:0];
  end

  assert_free_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!same_hit && any_free) |-> !valid_i[slot_o]);
  assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic               lk_store,
  input  logic               lk_user,
  output logic               lk_hit,
  output logic [PA_W-1:0]    lk_paddr,
  output logic               exc_miss,
  output logic               exc_prot,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PID_W-1:0]   fill_pid,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               fill_wr,
  input  logic               flush_all,
  input  logic               flush_pid_en,
  input  logic [PID_W-1:0]   flush_pid,
  input  logic               ref_clr,
  output logic [NUM_ENT-1:0] ref_bits,
  output logic [NUM_ENT-1:0] dirty_bits
);
  xlat_ent_t          ent_q   [NUM_ENT];
  logic [NUM_ENT-1:0] valid_q, refd_q, dirty_q;

  logic [NUM_ENT-1:0] lk_vec, fl_vec;
  logic               lk_match, fl_match;
  logic [IDX_W-1:0]   lk_idx, fl_idx, fill_slot;
  logic               wr_denied, dirty_set, fill_take;

  xlat_match u_lk_match (
    .ent_i(ent_q), .valid_i(valid_q),
    .key_vpn(lk_vaddr[VA_W-1:OFS_W]), .key_pid(lk_pid),
    .hit_vec(lk_vec), .hit(lk_match), .idx(lk_idx)
  );

  xlat_match u_fill_match (
    .ent_i(ent_q), .valid_i(valid_q),
    .key_vpn(fill_vpn), .key_pid(fill_pid),
    .hit_vec(fl_vec), .hit(fl_match), .idx(fl_idx)
  );

  xlat_victim u_victim (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_q),
    .same_hit(fl_match), .same_idx(fl_idx), .slot_o(fill_slot)
  );

  // Lookup path: one cycle, no stored state on the way out.
  assign lk_hit    = lk_valid && lk_match;
  assign wr_denied = lk_store && lk_user && !ent_q[lk_idx].wr;
  assign exc_miss  = lk_valid && !lk_match;
  assign exc_prot  = lk_hit && wr_denied;
  assign dirty_set = lk_hit && lk_store && !wr_denied;
  assign lk_paddr  = lk_hit ? join_pa(ent_q[lk_idx].ppn, lk_vaddr[OFS_W-1:0]) : '0;
  assign fill_take = fill_en && !flush_all;

  assign ref_bits   = refd_q;
  assign dirty_bits = dirty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      refd_q  <= '0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (flush_all)
          valid_q[i] <= 1'b0;
        else if (flush_pid_en && ent_q[i].pid == flush_pid)
          valid_q[i] <= 1'b0;
      end
      if (ref_clr)   refd_q <= '0;
      if (lk_hit)    refd_q[lk_idx] <= 1'b1;
      if (dirty_set) dirty_q[lk_idx] <= 1'b1;
      if (fill_take) begin
        ent_q[fill_slot]   <= '{vpn: fill_vpn, pid: fill_pid, ppn: fill_ppn, wr: fill_wr};
        valid_q[fill_slot] <= 1'b1;
        refd_q[fill_slot]  <= 1'b0;
        dirty_q[fill_slot] <= 1'b0;
      end
    end
  end

  assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));
  assert_miss_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_miss && (lk_hit || exc_prot)));
  assert_ref_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !fill_en) |=> ref_bits[$past(lk_idx)]);
  assert_prot_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_prot && !fill_en) |=> $stable(dirty_bits));
  assert_flush_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);
  assert_miss_paddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_miss |-> lk_paddr == '0);
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_store = 0, lk_user = 0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_hit, exc_miss, exc_prot;
  logic [29:0] lk_paddr;
  logic        fill_en = 0, fill_wr = 0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_pid = '0;
  logic [17:0] fill_ppn = '0;
  logic        flush_all = 0, flush_pid_en = 0, ref_clr = 0;
  logic [7:0]  flush_pid = '0;
  logic [15:0] ref_bits, dirty_bits;

  int checks = 0, fails = 0;
  logic        r_hit, r_miss, r_prot;
  logic [29:0] r_pa;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_pid(lk_pid), .lk_store(lk_store), .lk_user(lk_user), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .exc_miss(exc_miss), .exc_prot(exc_prot),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_ppn(fill_ppn), .fill_wr(fill_wr), .flush_all(flush_all),
    .flush_pid_en(flush_pid_en), .flush_pid(flush_pid), .ref_clr(ref_clr),
    .ref_bits(ref_bits), .dirty_bits(dirty_bits)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic look(input logic [19:0] vpn, input logic [11:0] ofs, input logic [7:0] pid,
                      input logic st, input logic usr);
    lk_valid = 1; lk_vaddr = {vpn, ofs}; lk_pid = pid; lk_store = st; lk_user = usr;
    #1;
    r_hit = lk_hit; r_miss = exc_miss; r_prot = exc_prot; r_pa = lk_paddr;
    @(negedge clk);
    lk_valid = 0; lk_store = 0; lk_user = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [17:0] ppn, input logic wr);
    fill_en = 1; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn; fill_wr = wr;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic clear_ref();
    ref_clr = 1; @(negedge clk); ref_clr = 0;
  endtask

  task automatic t_reset();
    chk(ref_bits == 0, "R2 ref after reset", 32'(ref_bits), 0);
    chk(dirty_bits == 0, "R2 dirty after reset", 32'(dirty_bits), 0);
    look(20'h00000, 12'h000, 8'h00, 0, 0);
    chk(r_miss && !r_hit, "R2 reset lookup misses", {r_hit, r_miss}, 32'b01);
    chk(r_pa == 0, "R5 miss paddr zero", r_pa, 0);
  endtask

  task automatic t_translate();
    fill(20'hA0001, 8'd1, 18'h12345, 1);           // slot 0
    look(20'hA0001, 12'hABC, 8'd1, 0, 1);
    chk(r_hit && !r_miss && !r_prot, "R9 hit flags", {r_hit, r_miss, r_prot}, 32'b100);
    chk(r_pa == {18'h12345, 12'hABC}, "R9 paddr", r_pa, {18'h12345, 12'hABC});
    clear_ref();
    look(20'hA0001, 12'h000, 8'd2, 0, 1);
    chk(r_miss && !r_hit, "R1 other pid misses", {r_hit, r_miss}, 32'b01);
    chk(ref_bits == 0, "R5 miss keeps state", 32'(ref_bits), 0);
    fill(20'hA0001, 8'd2, 18'h00777, 1);           // slot 1
    look(20'hA0001, 12'h010, 8'd2, 0, 1);
    chk(r_pa == {18'h00777, 12'h010}, "R1 pid2 own ppn", r_pa, {18'h00777, 12'h010});
    look(20'hA0001, 12'h010, 8'd1, 0, 1);
    chk(r_pa == {18'h12345, 12'h010}, "R1 pid1 still resident", r_pa, {18'h12345, 12'h010});
  endtask

  task automatic t_ref();
    clear_ref();
    chk(ref_bits == 0, "R3 ref clear", 32'(ref_bits), 0);
    look(20'hA0001, 12'h000, 8'd2, 0, 1);
    chk(ref_bits == 16'h0002, "R3 hit sets ref", 32'(ref_bits), 32'h2);
  endtask

  task automatic t_write();
    look(20'hA0001, 12'h004, 8'd1, 1, 1);
    chk(!r_prot && dirty_bits == 16'h0001, "R4 store sets dirty", 32'(dirty_bits), 32'h1);
    fill(20'hB0002, 8'd1, 18'h0BEEF, 0);           // slot 2, read-only
    look(20'hB0002, 12'h008, 8'd1, 0, 1);
    chk(r_hit && !r_prot, "R6 user load ok", {r_hit, r_prot}, 32'b10);
    look(20'hB0002, 12'h008, 8'd1, 1, 1);
    chk(r_prot && !r_miss, "R6 user store faults", {r_prot, r_miss}, 32'b10);
    chk(dirty_bits[2] == 0, "R6 no dirty on fault", 32'(dirty_bits), 32'h1);
    look(20'hB0002, 12'h008, 8'd1, 1, 0);
    chk(!r_prot && dirty_bits[2], "R7 supervisor store", 32'(dirty_bits), 32'h5);
  endtask

  task automatic t_refill_same();
    fill(20'hA0001, 8'd1, 18'h2AAAA, 1);           // overwrites slot 0
    chk(dirty_bits[0] == 0, "R12 refill clears dirty", 32'(dirty_bits), 32'h4);
    clear_ref();
    look(20'hA0001, 12'h001, 8'd1, 0, 1);
    chk(r_pa == {18'h2AAAA, 12'h001}, "R8 same-tag refill value", r_pa, {18'h2AAAA, 12'h001});
    chk(ref_bits == 16'h0001, "R8 same-tag refill slot", 32'(ref_bits), 32'h1);
  endtask

  task automatic t_pid_flush();
    flush_pid_en = 1; flush_pid = 8'd1; @(negedge clk); flush_pid_en = 0;
    look(20'hA0001, 12'h0, 8'd1, 0, 1);
    chk(r_miss, "R11 pid1 page A gone", r_miss, 1);
    look(20'hB0002, 12'h0, 8'd1, 0, 1);
    chk(r_miss, "R11 pid1 page B gone", r_miss, 1);
    look(20'hA0001, 12'h0, 8'd2, 0, 1);
    chk(r_hit, "R11 pid2 kept", r_hit, 1);
    // slots 0 and 2 free, slot 1 valid: next refill must land in slot 0
    fill(20'hC0003, 8'd3, 18'h00003, 1);
    clear_ref();
    look(20'hC0003, 12'h0, 8'd3, 0, 1);
    chk(ref_bits == 16'h0001, "R8 lowest free slot", 32'(ref_bits), 32'h1);
  endtask

  task automatic t_flush_all();
    flush_all = 1; fill_en = 1; fill_vpn = 20'hD0004; fill_pid = 8'd4; fill_ppn = 18'h4; fill_wr = 1;
    @(negedge clk);
    flush_all = 0; fill_en = 0;
    look(20'hA0001, 12'h0, 8'd2, 0, 1);
    chk(r_miss, "R10 entry gone", r_miss, 1);
    look(20'hC0003, 12'h0, 8'd3, 0, 1);
    chk(r_miss, "R10 entry gone", r_miss, 1);
    look(20'hD0004, 12'h0, 8'd4, 0, 1);
    chk(r_miss, "R10 fill dropped", r_miss, 1);
  endtask

  task automatic t_full_replace(input logic [19:0] base, input logic [19:0] extra);
    int n;
    flush_all = 1; @(negedge clk); flush_all = 0;
    for (int i = 0; i < 16; i++) fill(base + 20'(i), 8'd5, 18'(i), 1);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      look(base + 20'(i), 12'h0, 8'd5, 0, 1);
      if (r_hit) n++;
    end
    chk(n == 16, "R8 all sixteen resident", n, 16);
    repeat (3) @(negedge clk);
    fill(extra, 8'd5, 18'h3FFFF, 1);
    look(extra, 12'h0, 8'd5, 0, 1);
    chk(r_hit && r_pa == {18'h3FFFF, 12'h0}, "R8 new page resident", r_pa, {18'h3FFFF, 12'h0});
    n = 0;
    for (int i = 0; i < 16; i++) begin
      look(base + 20'(i), 12'h0, 8'd5, 0, 1);
      if (r_hit) n++;
    end
    chk(n == 15, "R8 exactly one victim", n, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_ref();
    t_write();
    t_refill_same();
    t_pid_flush();
    t_flush_all();
    t_full_replace(20'h00100, 20'h00200);
    t_full_replace(20'h00300, 20'h00400);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule